// File: doc/BRIEF.md
# Six-Bit Binary Rate Multiplier

This block passes a chosen fraction of its input clock pulses through to its output. A free-running counter advances on each enabled rising edge of `clk_i`. Each bit of the rate word `rate_i` selects its own set of counter states. A pulse appears on the active-low output `z_no` during the low half of every clock period whose counter state is selected. Over any aligned 64-clock window, the number of output pulses equals the binary value of the rate word. The bits are decoded against states that never overlap, so the pulses are spread over the window instead of arriving in bursts.

Stages can be combined in two ways. Feeding one stage's `z_no` into the next stage's clock multiplies the two rates. The `en_no` terminal-count output can drive a following stage's count enable. `cascade_i` gates the active-high copy `y_o`, which is the NAND of `z_no` and `cascade_i`. A high `inhibit_i` blocks every output pulse and leaves the counter running. `clr_i` asynchronously parks the counter at zero.

Top module: `rate_mult`

## Requirements
- R1: The counter advances by one, wrapping from 63 to 0, on each rising `clk_i` while `en_ni` is low and `clr_i` is low. It holds its value while `en_ni` is high.
- R2: `clr_i` high forces the counter to 0 at once, with no clock edge needed, and holds it there. The outputs immediately reflect state 0.
- R3: Rate bit i (weight 2^i) selects the counter states c whose count of trailing one bits is exactly 5-i. Bit 5 selects even states, bit 4 selects states ending in binary 01, and so on. Bit 0 selects state 31 only. State 63 is never selected.
- R4: Over 64 consecutive counted clocks starting at state 0, `z_no` pulses low exactly `rate_i` times, for every rate value from 0 to 63.
- R5: `z_no` is low only while `clk_i` is low, `inhibit_i` is low and the current state is selected.
- R6: `inhibit_i` high keeps `z_no` high. The counter keeps advancing meanwhile.
- R7: `y_o` equals NOT(`z_no` AND `cascade_i`). It is high whenever `cascade_i` is low.
- R8: `en_no` is low exactly when the counter is 63 and `en_ni` is low.
- R9: Reset (`rst_ni` low) clears the counter to 0. `z_no` is high when `rate_i` is 0, and `en_no` is high.
- R10: Two stages with the second clocked by the first stage's `z_no` produce rate1*rate2 pulses on the second `z_no` per 4096 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counted clock; its low half also gates the output pulses |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Asynchronous counter clear, active high |
| en_ni | input | 1 | Count enable, active low |
| inhibit_i | input | 1 | Output strobe; high blocks all pulses |
| cascade_i | input | 1 | Gate for `y_o` |
| rate_i | input | 6 | Rate word; bit 5 has weight 32 |
| z_no | output | 1 | Active-low output pulse train |
| y_o | output | 1 | NAND of `z_no` and `cascade_i` |
| en_no | output | 1 | Terminal count, active low |

## Verification
An asynchronous clear and a selected output pulse can land in the same clock-low half. So can the terminal count and a clear. The bench provokes both cases. It brings the counter to an odd state with only the even-state bit set, and separately to state 63. It then raises `clr_i` in the middle of the low phase, with no clock edge. It judges the result a moment later: `z_no` must fall at once, because state 0 is selected, and `en_no` must return high. Count enable and terminal count also coincide at state 63. That case is checked by stalling the counter there with `en_ni` high and requiring `en_no` to rise while the pulse pattern stays frozen.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int unsigned RM_WIDTH = 6;
endpackage

// File: rtl/rm_counter.sv
module rm_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_ni,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  // clear is asynchronous, like reset
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!en_ni) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q;
endmodule

// File: rtl/rm_decode.sv
module rm_decode #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rate_i,
  output logic [W-1:0] hit_o
);
  // bit i: low (W-1-i) bits all ones, next bit zero
  for (genvar i = 0; i < W; i++) begin : g_term
    localparam int unsigned L = W - 1 - i;
    localparam logic [W-1:0] MASK = W'((64'd1 << (L + 1)) - 64'd1);
    localparam logic [W-1:0] PAT  = W'((64'd1 << L) - 64'd1);
    assign hit_o[i] = rate_i[i] && ((cnt_i & MASK) == PAT);
  end
endmodule

// File: rtl/rm_outputs.sv
module rm_outputs #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         inhibit_i,
  input  logic         cascade_i,
  input  logic         en_ni,
  input  logic         last_i,
  input  logic [W-1:0] hit_i,
  output logic         z_no,
  output logic         y_o,
  output logic         en_no
);
  logic pulse;

  // pulse only in the low half of the clock
  always_comb begin
    pulse = (|hit_i) && !clk_i && !inhibit_i;
    z_no  = !pulse;
    y_o   = !(z_no && cascade_i);
    en_no = !(last_i && !en_ni);
  end
endmodule

// File: rtl/rate_mult.sv
module rate_mult
  import rm_pkg::*;
#(
  parameter int unsigned W = RM_WIDTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_ni,
  input  logic         inhibit_i,
  input  logic         cascade_i,
  input  logic [W-1:0] rate_i,
  output logic         z_no,
  output logic         y_o,
  output logic         en_no
);
  logic [W-1:0] cnt;
  logic [W-1:0] hit;
  logic         last;

  rm_counter #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_ni  (en_ni),
    .cnt_o  (cnt),
    .last_o (last)
  );

  rm_decode #(.W(W)) u_dec (
    .cnt_i  (cnt),
    .rate_i (rate_i),
    .hit_o  (hit)
  );

  rm_outputs #(.W(W)) u_out (
    .clk_i     (clk_i),
    .inhibit_i (inhibit_i),
    .cascade_i (cascade_i),
    .en_ni     (en_ni),
    .last_i    (last),
    .hit_i     (hit),
    .z_no      (z_no),
    .y_o       (y_o),
    .en_no     (en_no)
  );
endmodule

// File: rtl/rate_mult_chk.sv
module rate_mult_chk #(
  parameter int unsigned W = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         en_ni,
  input logic         inhibit_i,
  input logic         cascade_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] hit_i,
  input logic         z_no,
  input logic         y_o,
  input logic         en_no
);
  // sampled values at the rising edge are those of the low phase
  AST_CNT_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    !en_ni |=> cnt_i == $past(cnt_i) + 1'b1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    en_ni |=> $stable(cnt_i)); // R1
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> cnt_i == '0); // R2
  AST_ONE_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_i)); // R4
  AST_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !z_no |-> (!inhibit_i && hit_i != '0)); // R5
  AST_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> z_no); // R6
  AST_Y_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cascade_i |-> y_o); // R7
  AST_TERM_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_no |-> (cnt_i == '1 && !en_ni)); // R8
endmodule

bind rate_mult rate_mult_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .en_ni     (en_ni),
  .inhibit_i (inhibit_i),
  .cascade_i (cascade_i),
  .cnt_i     (cnt),
  .hit_i     (hit),
  .z_no      (z_no),
  .y_o       (y_o),
  .en_no     (en_no)
);

// File: tb/rate_mult_test.sv
module rate_mult_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic en_n = 1'b0;
  logic inh = 1'b0;
  logic casc = 1'b1;
  logic [5:0] rate = '0;
  logic z_n, y, en_o;

  logic c_clr = 1'b0;
  logic [5:0] c_rate1 = '0;
  logic [5:0] c_rate2 = '0;
  logic c1_z, c1_y, c1_eno, c2_z, c2_y, c2_eno;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  int pulses2 = 0;
  logic cnt_on = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rate_mult uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_ni(en_n),
    .inhibit_i(inh), .cascade_i(casc), .rate_i(rate),
    .z_no(z_n), .y_o(y), .en_no(en_o));

  rate_mult c1 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(c_clr), .en_ni(1'b0),
    .inhibit_i(1'b0), .cascade_i(1'b1), .rate_i(c_rate1),
    .z_no(c1_z), .y_o(c1_y), .en_no(c1_eno));

  rate_mult c2 (
    .clk_i(c1_z), .rst_ni(rst_n), .clr_i(c_clr), .en_ni(1'b0),
    .inhibit_i(1'b0), .cascade_i(1'b1), .rate_i(c_rate2),
    .z_no(c2_z), .y_o(c2_y), .en_no(c2_eno));

  always @(negedge c2_z) if (cnt_on) pulses2++;

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic sel(int c, logic [5:0] r);
    int t = 0;
    while (t < 6 && c[t]) t++;
    return (t < 6) && r[5-t];
  endfunction

  // starts at posedge+5, ends at next posedge+5
  task automatic step();
    logic zx, yx, ex;
    #10;
    zx = !(sel(exp_cnt, rate) && !inh);
    yx = !(zx && casc);
    ex = !(exp_cnt == 63 && !en_n);
    chk("R3", int'(z_n), int'(zx));
    chk("R7", int'(y), int'(yx));
    chk("R8", int'(en_o), int'(ex));
    @(posedge clk);
    if (!en_n && !clr) exp_cnt = (exp_cnt + 1) % 64;
    #5;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(posedge clk); #5;
    clr = 1'b0;
    exp_cnt = 0;
  endtask

  task automatic t_reset();
    #25;
    chk("R9", int'(z_n), 1);
    chk("R9", int'(en_o), 1);
    @(posedge clk); #5;
    rst_n = 1'b1;
    exp_cnt = 0;
    rate = 6'b000001;
    repeat (66) step();  // R9 counter starts at 0, R8 low at 63
  endtask

  task automatic t_sweep();
    for (int r = 0; r < 64; r++) begin
      int lows = 0;
      rate = 6'(r);
      casc = r[1];
      do_clear();
      for (int k = 0; k < 64; k++) begin
        #10;
        if (!z_n) lows++;
        #0 ;
        #(-0);
        chk("R5", int'(z_n), int'(!sel(exp_cnt, rate)));
        chk("R7", int'(y), int'(!(z_n && casc)));
        @(posedge clk);
        exp_cnt = (exp_cnt + 1) % 64;
        #5;
      end
      chk("R4", lows, r);
    end
    casc = 1'b1;
  endtask

  task automatic t_hold();
    rate = 6'b000001;
    do_clear();
    repeat (63) step();
    step();              // R8 low at 63, R1 wrap to 0
    chk("R1", exp_cnt, 0);
    repeat (62) step();  // now at 62
    step();              // now at 63
    en_n = 1'b1;         // R1 hold at 63, R8 released
    repeat (5) step();
    en_n = 1'b0;
    repeat (34) step();  // wraps, passes 31
  endtask

  task automatic t_inhibit();
    rate = 6'b111111;
    do_clear();
    inh = 1'b1;          // R6 pulses blocked
    repeat (20) step();
    inh = 1'b0;          // R6 counter kept running
    repeat (44) step();
  endtask

  task automatic t_clear();
    rate = 6'b100000;
    do_clear();
    repeat (31) step();
    #10;
    chk("R2", int'(z_n), 1);   // state 31 odd
    clr = 1'b1;
    #1;
    chk("R2", int'(z_n), 0);   // state 0 even, no edge needed
    @(posedge clk); #5;
    clr = 1'b0;
    exp_cnt = 0;
    repeat (63) step();
    #10;
    chk("R2", int'(en_o), 0);  // at 63
    clr = 1'b1;
    #1;
    chk("R2", int'(en_o), 1);
    chk("R2", int'(z_n), 0);
    @(posedge clk); #5;
    clr = 1'b0;
    exp_cnt = 0;
    repeat (4) step();
  endtask

  task automatic t_chain(int r1, int r2);
    c_rate1 = 6'(r1);
    c_rate2 = 6'(r2);
    @(posedge clk); #5;
    c_clr = 1'b1;
    @(posedge clk); #5;
    c_clr = 1'b0;
    pulses2 = 0;
    cnt_on = 1'b1;
    repeat (4096) @(posedge clk);
    #5;
    cnt_on = 1'b0;
    chk("R10", pulses2, r1 * r2);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_inhibit();
    t_clear();
    t_chain(63, 63);
    t_chain(5, 12);
    t_chain(0, 33);
    t_chain(40, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule